// File: doc/BRIEF.md
# Fuse-Backed Station Address Loader

This block holds a six-byte station address in a small one-time-programmable fuse store. On command it copies those bytes into the MAC's unicast address registers. Software cannot write those registers directly. A successful load is the only way their contents change.

Software drives the block through two 32-bit control words and a byte-wide programming word, all reached over one write port. The first control word carries a command, an execute strobe and the status flags. The second control word carries a soft reset. The programming word replaces single address bytes in the fuse store.

A controller reset does not undo a programmed byte. Only a power-on reset of the fuse store brings back the factory address.

Commands take a fixed number of cycles: the fuse store answers each byte read after `RD_LAT` cycles. A watchdog of `TMO_CYCLES` cycles bounds every command. At 250 MHz, 27000 cycles corresponds to 108 microseconds.

Top module: `fuse_addr_loader`

## Requirements
- R1: After `rst_n`, the following all read zero:
  - the first control word (`ctl1_rd`)
  - the second control word (`ctl2_rd`)
  - the programming readback (`prog_rd`)
  - both address outputs (`uaddr_lo`, `uaddr_hi`)
- R2: Writing control word 1 (`cfg_sel`=0) with bit 27 set starts the command in bits 26:25: 01 load, 10 read, 11 blow. From the next cycle, bit 27 reads 1 until the command ends. An ended command shows exactly one of done (bit 0) and error (bit 16), with bit 27 cleared.
- R3: A successful load commits fuse bytes 0..5 to the address outputs. `uaddr_lo` holds bytes 3..0, with byte 0 in bits 7:0. `uaddr_hi` holds byte 5 in bits 15:8 and byte 4 in bits 7:0, and zero above. The outputs change on no other event.
- R4: A command still running `TMO_CYCLES` cycles after it started ends with error=1, done=0 and execute=0. A load that times out leaves the address outputs unchanged.
- R5: A write to control word 1 while execute reads 1 is ignored. This covers its command, byte-select and bit-select fields.
- R6: Control word 2 bit 15 (`cfg_sel`=1) is a soft reset and reads back as written. While it is 1:
  - a running command is aborted within one cycle;
  - execute, done and error are cleared;
  - new commands are ignored.
  After it is cleared, commands work again.
- R7: The read command (10) uses byte select (bits 15:8) and bit select (bits 6:4). The selected fuse byte is rotated right by the bit select, and its low four bits are returned in bits 31:28 with done=1. A byte select of 6 or more ends the command at once with error=1.
- R8: An execute strobe with command 11 or command 00 ends at once with error=1 and done=0.
- R9: A programming word (`cfg_sel`=2) is accepted when all of these hold:
  - bit 31 (strobe) is 1;
  - function (bits 30:28) is 0;
  - page (bits 27:24) is 1;
  - byte address (bits 23:16) equals `UADDR_BASE`+i for i in 0..5.
  An accepted word replaces fuse byte i with bits 15:8. The new value appears at the address outputs after the next load.
- R10: A strobed programming word that fails the R9 match leaves the fuse store unchanged. `prog_rd` returns the last strobed word with bit 31 cleared and a status in bits 7:0: 00 when accepted, 01 when rejected.
- R11: Programmed fuse bytes survive `rst_n`. Only `por_n` restores `FACTORY_ADDR`, whose byte i is bits 8i+7:8i.
- R12: Done and error are never both 1. Starting a new command clears both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low controller reset, released synchronously |
| por_n | input | 1 | Asynchronous active-low power-on reset of the fuse store |
| cfg_wr | input | 1 | Write strobe for the selected word |
| cfg_sel | input | 2 | Word select: 0 control 1, 1 control 2, 2 programming, 3 none |
| cfg_wdata | input | 32 | Write data |
| ctl1_rd | output | 32 | Control word 1 readback: command, selects, flags, read nibble |
| ctl2_rd | output | 32 | Control word 2 readback: soft reset in bit 15 |
| prog_rd | output | 32 | Last strobed programming word with its status |
| uaddr_lo | output | 32 | Station address bytes 3..0 |
| uaddr_hi | output | 32 | Station address bytes 5..4 |

## Verification
The bench builds two copies of the block that share one stimulus bus.

The first copy uses `RD_LAT`=3 and the full 27000-cycle limit. A load on it therefore ends after 24 cycles, which keeps the timing checks short.

The second copy is identical except that `TMO_CYCLES`=8. This limit is shorter than a six-byte load, so the same load stimulus drives the second copy into its timeout path. The bench then confirms that the timed-out copy leaves its address outputs untouched while the first copy commits.

// File: rtl/fal_pkg.sv
package fal_pkg;

  localparam int ADDR_BYTES = 6;
  localparam int IDX_W      = 3;

  localparam int EXEC_B = 27;
  localparam int ERR_B  = 16;
  localparam int DONE_B = 0;
  localparam int SRST_B = 15;
  localparam int STRB_B = 31;

  localparam logic [1:0] SEL_CTL1 = 2'd0;
  localparam logic [1:0] SEL_CTL2 = 2'd1;
  localparam logic [1:0] SEL_PROG = 2'd2;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'b00,
    CMD_LOAD = 2'b01,
    CMD_READ = 2'b10,
    CMD_BLOW = 2'b11
  } fal_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } fal_st_e;

endpackage

// File: rtl/fal_fuse_store.sv
module fal_fuse_store
  import fal_pkg::*;
#(
  parameter int          RD_LAT       = 3,
  parameter logic [47:0] FACTORY_ADDR = 48'h665544332211,
  parameter logic [7:0]  UADDR_BASE   = 8'h38
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_n,
  input  logic             pg_wr,
  input  logic [31:0]      pg_word,
  output logic [31:0]      pg_rd,
  input  logic             rd_req,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             rd_flush,
  output logic             rd_vld,
  output logic [7:0]       rd_data
);

  logic [ADDR_BYTES-1:0][7:0] fb_q, fb_d;
  logic [31:0]                pw_q, pw_d;
  logic [RD_LAT-1:0]          vld_q, vld_d;
  logic [RD_LAT-1:0][7:0]     dat_q, dat_d;
  logic [7:0]                 off;
  logic                       accept;
  logic                       strobed;
  logic                       unused_ok;

  assign off     = pg_word[23:16] - UADDR_BASE;
  assign accept  = (pg_word[30:28] == 3'd0) && (pg_word[27:24] == 4'd1) &&
                   (off < 8'(ADDR_BYTES));
  assign strobed = pg_wr && pg_word[STRB_B];
  assign unused_ok = ^pg_word[7:0];

  // fuse byte next state
  always_comb begin
    fb_d = fb_q;
    if (strobed && accept) fb_d[off[IDX_W-1:0]] = pg_word[15:8];
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int i = 0; i < ADDR_BYTES; i++) fb_q[i] <= FACTORY_ADDR[8*i +: 8];
    end else begin
      fb_q <= fb_d;
    end
  end

  // programming word readback
  always_comb begin
    pw_d = pw_q;
    if (strobed) pw_d = {1'b0, pg_word[30:8], accept ? 8'h00 : 8'h01};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pw_q <= '0;
    else        pw_q <= pw_d;
  end

  assign pg_rd = pw_q;

  // fixed-latency read pipeline
  assign vld_d[0] = rd_req && !rd_flush;
  assign dat_d[0] = (rd_idx < IDX_W'(ADDR_BYTES)) ? fb_q[rd_idx] : 8'h00;

  for (genvar k = 1; k < RD_LAT; k++) begin : g_stage
    assign vld_d[k] = vld_q[k-1] && !rd_flush;
    assign dat_d[k] = dat_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_d;
      dat_q <= dat_d;
    end
  end

  assign rd_vld  = vld_q[RD_LAT-1];
  assign rd_data = dat_q[RD_LAT-1];

  // R10
  rej_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
    (strobed && !accept) |=> $stable(fb_q));

  // R6
  flush_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_flush |=> !rd_vld);

endmodule

// File: rtl/fal_addr_regs.sv
module fal_addr_regs
  import fal_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_we,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [7:0]       ld_byte,
  input  logic             ld_commit,
  output logic [31:0]      uaddr_lo,
  output logic [31:0]      uaddr_hi
);

  logic [ADDR_BYTES-1:0][7:0] stg_q, stg_d;
  logic [ADDR_BYTES-1:0][7:0] ua_q, ua_d;

  always_comb begin
    stg_d = stg_q;
    if (ld_we && (ld_idx < IDX_W'(ADDR_BYTES))) stg_d[ld_idx] = ld_byte;
    ua_d = ld_commit ? stg_d : ua_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
      ua_q  <= '0;
    end else begin
      stg_q <= stg_d;
      ua_q  <= ua_d;
    end
  end

  assign uaddr_lo = {ua_q[3], ua_q[2], ua_q[1], ua_q[0]};
  assign uaddr_hi = {16'h0000, ua_q[5], ua_q[4]};

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_commit |=> $stable(ua_q));

endmodule

// File: rtl/fal_seq.sv
module fal_seq
  import fal_pkg::*;
#(
  parameter int TMO_CYCLES = 27000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_sel,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      ctl1_rd,
  output logic [31:0]      ctl2_rd,
  output logic             rd_req,
  output logic [IDX_W-1:0] rd_idx,
  output logic             rd_flush,
  input  logic             rd_vld,
  input  logic [7:0]       rd_data,
  output logic             ld_we,
  output logic [IDX_W-1:0] ld_idx,
  output logic [7:0]       ld_byte,
  output logic             ld_commit
);

  localparam int TMR_W = $clog2(TMO_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TMO_CYCLES - 1);

  fal_st_e          st_q, st_d;
  fal_cmd_e         cmd_q, cmd_d;
  logic             exec_q, exec_d;
  logic             done_q, done_d;
  logic             err_q, err_d;
  logic             srst_q, srst_d;
  logic [7:0]       bsel_q, bsel_d;
  logic [2:0]       bitsel_q, bitsel_d;
  logic [3:0]       nib_q, nib_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             ctl1_wr;
  logic             fin;
  logic [3:0]       rot_nib;
  logic             unused_ok;

  assign ctl1_wr   = cfg_wr && (cfg_sel == SEL_CTL1);
  assign unused_ok = ^{cfg_wdata[31:28], cfg_wdata[24:16], cfg_wdata[7], cfg_wdata[3:0]};

  always_comb begin
    for (int k = 0; k < 4; k++) rot_nib[k] = rd_data[bitsel_q + 3'(k)];
  end

  always_comb begin
    st_d = st_q;  cmd_d = cmd_q;  exec_d = exec_q;  done_d = done_q;
    err_d = err_q;  bsel_d = bsel_q;  bitsel_d = bitsel_q;  nib_d = nib_q;
    idx_d = idx_q;  tmr_d = tmr_q;  srst_d = srst_q;
    rd_req = 1'b0;  rd_flush = 1'b0;  ld_we = 1'b0;  ld_commit = 1'b0;
    fin = 1'b0;
    if (cfg_wr && (cfg_sel == SEL_CTL2)) srst_d = cfg_wdata[SRST_B];

    if (srst_q) begin
      st_d = ST_IDLE;  exec_d = 1'b0;  done_d = 1'b0;  err_d = 1'b0;
      tmr_d = '0;  rd_flush = 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (ctl1_wr) begin
            cmd_d    = fal_cmd_e'(cfg_wdata[26:25]);
            bsel_d   = cfg_wdata[15:8];
            bitsel_d = cfg_wdata[6:4];
            if (cfg_wdata[EXEC_B]) begin
              done_d = 1'b0;
              err_d  = 1'b0;
              tmr_d  = '0;
              if (cmd_d == CMD_LOAD) begin
                exec_d = 1'b1;  idx_d = '0;  st_d = ST_ISSUE;
              end else if (cmd_d == CMD_READ && bsel_d < 8'(ADDR_BYTES)) begin
                exec_d = 1'b1;  idx_d = bsel_d[IDX_W-1:0];  st_d = ST_ISSUE;
              end else begin
                err_d = 1'b1;
              end
            end
          end
        end
        ST_ISSUE: begin
          rd_req = 1'b1;
          st_d   = ST_WAIT;
        end
        ST_WAIT: begin
          if (rd_vld) begin
            if (cmd_q == CMD_LOAD) begin
              ld_we = 1'b1;
              if (idx_q == IDX_W'(ADDR_BYTES - 1)) begin
                ld_commit = 1'b1;  fin = 1'b1;
              end else begin
                idx_d = idx_q + 1'b1;  st_d = ST_ISSUE;
              end
            end else begin
              nib_d = rot_nib;  fin = 1'b1;
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase

      if (st_q != ST_IDLE) begin
        tmr_d = tmr_q + 1'b1;
        if (fin) begin
          done_d = 1'b1;  exec_d = 1'b0;  st_d = ST_IDLE;
        end else if (tmr_q == TMR_LAST) begin
          err_d = 1'b1;  exec_d = 1'b0;  st_d = ST_IDLE;  rd_flush = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  cmd_q <= CMD_NOP;  exec_q <= 1'b0;  done_q <= 1'b0;
      err_q <= 1'b0;  srst_q <= 1'b0;  bsel_q <= '0;  bitsel_q <= '0;
      nib_q <= '0;  idx_q <= '0;  tmr_q <= '0;
    end else begin
      st_q <= st_d;  cmd_q <= cmd_d;  exec_q <= exec_d;  done_q <= done_d;
      err_q <= err_d;  srst_q <= srst_d;  bsel_q <= bsel_d;  bitsel_q <= bitsel_d;
      nib_q <= nib_d;  idx_q <= idx_d;  tmr_q <= tmr_d;
    end
  end

  assign rd_idx  = idx_q;
  assign ld_idx  = idx_q;
  assign ld_byte = rd_data;

  assign ctl1_rd = {nib_q, exec_q, cmd_q, 8'h00, err_q, bsel_q, 1'b0,
                    bitsel_q, 3'b000, done_q};
  assign ctl2_rd = {16'h0000, srst_q, 15'h0000};

  // R12
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && err_q));

  // R4
  tmo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_q |-> (tmr_q < TMR_W'(TMO_CYCLES)));

  // R5
  busy_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_q && ctl1_wr) |=> ($stable(cmd_q) && $stable(bsel_q) && $stable(bitsel_q)));

  // R6
  srst_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (!exec_q && !done_q && !err_q));

  // R2
  end_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(exec_q) && !$past(srst_q)) |-> (done_q != err_q));

endmodule

// File: rtl/fuse_addr_loader.sv
module fuse_addr_loader
  import fal_pkg::*;
#(
  parameter int          RD_LAT       = 3,
  parameter int          TMO_CYCLES   = 27000,
  parameter logic [47:0] FACTORY_ADDR = 48'h665544332211,
  parameter logic [7:0]  UADDR_BASE   = 8'h38
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        por_n,
  input  logic        cfg_wr,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] ctl1_rd,
  output logic [31:0] ctl2_rd,
  output logic [31:0] prog_rd,
  output logic [31:0] uaddr_lo,
  output logic [31:0] uaddr_hi
);

  logic             rd_req, rd_flush, rd_vld;
  logic [IDX_W-1:0] rd_idx, ld_idx;
  logic [7:0]       rd_data, ld_byte;
  logic             ld_we, ld_commit;

  fal_seq #(.TMO_CYCLES(TMO_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ctl1_rd(ctl1_rd), .ctl2_rd(ctl2_rd),
    .rd_req(rd_req), .rd_idx(rd_idx), .rd_flush(rd_flush), .rd_vld(rd_vld),
    .rd_data(rd_data), .ld_we(ld_we), .ld_idx(ld_idx), .ld_byte(ld_byte),
    .ld_commit(ld_commit)
  );

  fal_fuse_store #(
    .RD_LAT(RD_LAT), .FACTORY_ADDR(FACTORY_ADDR), .UADDR_BASE(UADDR_BASE)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .por_n(por_n),
    .pg_wr(cfg_wr && (cfg_sel == SEL_PROG)), .pg_word(cfg_wdata),
    .pg_rd(prog_rd), .rd_req(rd_req), .rd_idx(rd_idx), .rd_flush(rd_flush),
    .rd_vld(rd_vld), .rd_data(rd_data)
  );

  fal_addr_regs u_addr (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_idx(ld_idx),
    .ld_byte(ld_byte), .ld_commit(ld_commit),
    .uaddr_lo(uaddr_lo), .uaddr_hi(uaddr_hi)
  );

endmodule

// File: tb/fuse_addr_loader_test.sv
module fuse_addr_loader_test;

  logic        clk, rst_n, por_n, cfg_wr;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic [31:0] c1, c2, pr, lo, hi;
  logic [31:0] t_c1, t_c2, t_pr, t_lo, t_hi;
  int n_vec, n_bad;

  localparam logic [47:0] FAC = 48'h665544332211;

  fuse_addr_loader #(.RD_LAT(3), .TMO_CYCLES(27000), .FACTORY_ADDR(FAC)) uut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ctl1_rd(c1), .ctl2_rd(c2), .prog_rd(pr),
    .uaddr_lo(lo), .uaddr_hi(hi));

  fuse_addr_loader #(.RD_LAT(3), .TMO_CYCLES(8), .FACTORY_ADDR(FAC)) uut_tmo (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ctl1_rd(t_c1), .ctl2_rd(t_c2), .prog_rd(t_pr),
    .uaddr_lo(t_lo), .uaddr_hi(t_hi));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_wdata = '0;
  endtask

  function automatic logic [31:0] c1w(input logic ex, input logic [1:0] cmd,
                                      input logic [7:0] bs, input logic [2:0] bt);
    return {4'h0, ex, cmd, 9'h0, bs, 1'b0, bt, 4'h0};
  endfunction

  function automatic logic [31:0] pgw(input logic [2:0] fn, input logic [3:0] pg,
                                      input logic [7:0] a, input logic [7:0] d);
    return {1'b1, fn, pg, a, d, 8'h00};
  endfunction

  function automatic logic [3:0] rot4(input logic [7:0] b, input int s);
    logic [7:0] r;
    r = (b >> s) | (b << (8 - s));
    return r[3:0];
  endfunction

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (c1[27] === 1'b1 && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic do_reset(input logic por);
    @(negedge clk);
    rst_n = 1'b0;
    if (por) por_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset(1'b1);
    chk("R1 ctl1", c1, 32'h0);
    chk("R1 ctl2", c2, 32'h0);
    chk("R1 prog", pr, 32'h0);
    chk("R1 lo", lo, 32'h0);
    chk("R1 hi", hi, 32'h0);
  endtask

  task automatic t_load;
    int cyc;
    wr(2'd0, c1w(1'b1, 2'b01, 8'h0, 3'd0));
    chk("R2 exec set", {31'h0, c1[27]}, 32'h1);
    chk("R3 lo unchanged while running", lo, 32'h0);
    wait_idle(cyc);
    chk("R2 done", {31'h0, c1[0]}, 32'h1);
    chk("R2 err", {31'h0, c1[16]}, 32'h0);
    chk("R2 time", {31'h0, (cyc <= 30)}, 32'h1);
    chk("R3 lo", lo, 32'h44332211);
    chk("R3 hi", hi, 32'h00006655);
  endtask

  task automatic t_busy;
    int cyc;
    wr(2'd0, c1w(1'b1, 2'b01, 8'h0, 3'd0));
    chk("R12 flags cleared on start", {30'h0, c1[16], c1[0]}, 32'h0);
    wr(2'd0, c1w(1'b1, 2'b10, 8'h3, 3'd5));
    chk("R5 cmd kept", {30'h0, c1[26:25]}, 32'h1);
    chk("R5 selects kept", {20'h0, c1[15:8], 1'b0, c1[6:4]}, 32'h0);
    wait_idle(cyc);
    chk("R5 load finished", {31'h0, c1[0]}, 32'h1);
  endtask

  task automatic t_read;
    int cyc;
    wr(2'd0, c1w(1'b1, 2'b10, 8'd1, 3'd0));
    wait_idle(cyc);
    chk("R7 nib b1 s0", {28'h0, c1[31:28]}, {28'h0, rot4(8'h22, 0)});
    chk("R7 done", {31'h0, c1[0]}, 32'h1);
    wr(2'd0, c1w(1'b1, 2'b10, 8'd5, 3'd6));
    wait_idle(cyc);
    chk("R7 nib b5 s6", {28'h0, c1[31:28]}, {28'h0, rot4(8'h66, 6)});
    wr(2'd0, c1w(1'b1, 2'b10, 8'd7, 3'd0));
    chk("R7 bad select err/done/exec", {29'h0, c1[27], c1[16], c1[0]}, 32'h2);
  endtask

  task automatic t_blow;
    int cyc;
    wr(2'd0, c1w(1'b1, 2'b11, 8'd0, 3'd0));
    chk("R8 blow err", {29'h0, c1[27], c1[16], c1[0]}, 32'h2);
    wr(2'd0, c1w(1'b1, 2'b00, 8'd0, 3'd0));
    chk("R8 nop err", {29'h0, c1[27], c1[16], c1[0]}, 32'h2);
    wr(2'd0, c1w(1'b1, 2'b01, 8'd0, 3'd0));
    chk("R12 err cleared on start", {31'h0, c1[16]}, 32'h0);
    wait_idle(cyc);
    chk("R12 done only", {30'h0, c1[16], c1[0]}, 32'h1);
  endtask

  task automatic t_srst;
    int cyc;
    wr(2'd0, c1w(1'b1, 2'b01, 8'd0, 3'd0));
    wr(2'd1, 32'h0000_8000);
    chk("R6 readback", c2, 32'h0000_8000);
    @(negedge clk);
    chk("R6 aborted", {29'h0, c1[27], c1[16], c1[0]}, 32'h0);
    wr(2'd0, c1w(1'b1, 2'b01, 8'd0, 3'd0));
    @(negedge clk);
    chk("R6 ignored while held", {31'h0, c1[27]}, 32'h0);
    wr(2'd1, 32'h0);
    wr(2'd0, c1w(1'b1, 2'b01, 8'd0, 3'd0));
    chk("R6 runs after release", {31'h0, c1[27]}, 32'h1);
    wait_idle(cyc);
    chk("R6 done after release", {31'h0, c1[0]}, 32'h1);
  endtask

  task automatic t_tmo;
    do_reset(1'b0);
    wr(2'd0, c1w(1'b1, 2'b01, 8'd0, 3'd0));
    repeat (40) @(negedge clk);
    chk("R4 tmo flags", {29'h0, t_c1[27], t_c1[16], t_c1[0]}, 32'h2);
    chk("R4 tmo lo kept", t_lo, 32'h0);
    chk("R4 tmo hi kept", t_hi, 32'h0);
    chk("R4 full limit completes", {30'h0, c1[16], c1[0]}, 32'h1);
  endtask

  task automatic t_prog;
    int cyc;
    wr(2'd2, pgw(3'd0, 4'd1, 8'h38, 8'hA5));
    chk("R10 accept status", pr, {1'b0, 3'd0, 4'd1, 8'h38, 8'hA5, 8'h00});
    wr(2'd2, pgw(3'd0, 4'd1, 8'h3D, 8'h7E));
    wr(2'd2, pgw(3'd0, 4'd0, 8'h39, 8'hEE));
    chk("R10 page reject", pr[7:0], 32'h01);
    wr(2'd2, pgw(3'd0, 4'd1, 8'h3E, 8'hEE));
    chk("R10 range reject", pr[7:0], 32'h01);
    wr(2'd2, pgw(3'd1, 4'd1, 8'h3A, 8'hEE));
    chk("R10 func reject", pr[7:0], 32'h01);
    wr(2'd0, c1w(1'b1, 2'b01, 8'd0, 3'd0));
    wait_idle(cyc);
    chk("R9 lo programmed", lo, 32'h443322A5);
    chk("R9 hi programmed", hi, 32'h00007E55);
  endtask

  task automatic t_persist;
    int cyc;
    do_reset(1'b0);
    chk("R1 lo after reset", lo, 32'h0);
    wr(2'd0, c1w(1'b1, 2'b01, 8'd0, 3'd0));
    wait_idle(cyc);
    chk("R11 kept over rst_n", lo, 32'h443322A5);
    do_reset(1'b1);
    wr(2'd0, c1w(1'b1, 2'b01, 8'd0, 3'd0));
    wait_idle(cyc);
    chk("R11 por lo", lo, 32'h44332211);
    chk("R11 por hi", hi, 32'h00006655);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    n_vec = 0; n_bad = 0;
    rst_n = 1'b0; por_n = 1'b0; cfg_wr = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    t_reset();
    t_load();
    t_busy();
    t_read();
    t_blow();
    t_srst();
    t_tmo();
    t_prog();
    t_persist();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule